// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel flash bus. It accepts one request at a time: program a byte, erase a sector, or erase a whole chip. It then drives the address, data, write-enable, output-enable and chip-select lines through the unlock and command write cycles that the flash expects. Every pulse width, hold time and recovery time is counted in system clocks. The counts are derived from nanosecond parameters and rounded up.

After the last command write, the block stops driving data and enters a read loop on the target location. Each read compares data bit 7 with the value it expects. For a program this is bit 7 of the programmed byte. For either erase it is 1. A match ends the operation with a one-cycle `done` pulse. If the match never arrives within a set number of reads, `done` is reported together with `err`.

The flash module has several chip selects, and two of them share each byte lane. A request carries a chip-select index. Only that one select is pulled low, so two devices can never drive the same lane together.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `fl_we_n` and `fl_oe_n` are 1, every bit of `fl_cs_n` is 1 and `fl_dq_oe` is 0.
- R2: A program request (`req_op`=2'b00) issues exactly four write cycles, in this order: data 8'hAA at address 21'h5555, 8'h55 at 21'h2AAA, 8'hA0 at 21'h5555, and finally the request data at the request address.
- R3: An erase request issues exactly six write cycles, in this order: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then a final write. For a sector erase (`req_op`=2'b01) the final write is 8'h30 at the request address. For a chip erase (`req_op`=2'b10) it is 8'h10 at 21'h5555.
- R4: Each write-enable low pulse lasts at least ceil(45 ns / clock) cycles. Within one request, write enable stays high between pulses for at least the larger of ceil(20 ns / clock) and ceil(90 ns / clock) minus the low-pulse cycles. Address and data do not change while write enable is low.
- R5: Output enable and write enable are never low together. After the last write-enable rise, output enable stays high for at least ceil(10 ns / clock) cycles before the first polling read.
- R6: Each polling read keeps output enable low for ceil(90 ns / clock) cycles at the request address. The operation completes without error on the first read whose `fl_dq_in[7]` equals the expected value: `req_data[7]` for a program and 1 for an erase. No further read follows that one.
- R7: If POLL_LIMIT reads in a row all return the complement, the operation ends with `done` and `err` both high after exactly POLL_LIMIT reads.
- R8: While busy, exactly one bit of `fl_cs_n` is low: the bit indexed by the latched `req_sel`. While idle, all bits are high.
- R9: A `req_valid` that arrives while busy is ignored, and so is a request with `req_op`=2'b11. Neither changes the bus activity.
- R10: `done` is a one-cycle pulse. `busy` is already low in that cycle. `err` is only high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 ignored |
| req_addr | input | AW | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| req_sel | input | SEL_W | Index of the chip select to use |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached, valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Write data toward the flash |
| fl_dq_oe | output | 1 | Host drives the data lane |
| fl_dq_in | input | 8 | Read data from the flash |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_cs_n | output | NCS | Chip selects, active low |

## Verification
The bench runs all three request kinds. A program and a chip erase tell apart a final write at the request address from one at the fixed unlock address, and the six-write erase prefix from the four-write program prefix. Programs with data bit 7 set and clear show that polling compares against the written bit and not a constant. Flash models that report busy for zero, a few and an unbounded number of reads separate immediate completion, a multi-read poll and the timeout. Further runs drive a request during an operation, send the reserved opcode and use a non-zero chip-select index, which exposes stray writes and wrong or extra selects.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int CLK_NS     = 10,
  parameter int AW         = 21,
  parameter int NCS        = 4,
  parameter int SEL_W      = 2,
  parameter int TWP_NS     = 45,
  parameter int TWPH_NS    = 20,
  parameter int TWC_NS     = 90,
  parameter int TOEH_NS    = 10,
  parameter int TACC_NS    = 90,
  parameter int POLL_LIMIT = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_data,
  input  logic [SEL_W-1:0] req_sel,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [AW-1:0]    fl_addr,
  output logic [7:0]       fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [7:0]       fl_dq_in,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic [NCS-1:0]   fl_cs_n
);
  localparam int WP_R    = (TWP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WPH_R   = (TWPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_R    = (TWC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OEH_R   = (TOEH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_R    = (TACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC  = (WP_R  < 1) ? 1 : WP_R;
  localparam int WPH_CYC = (WPH_R < 1) ? 1 : WPH_R;
  localparam int OEH_CYC = (OEH_R < 1) ? 1 : OEH_R;
  localparam int RD_CYC  = (RD_R  < 1) ? 1 : RD_R;
  localparam int HI_CYC  = (WC_R - WP_CYC > WPH_CYC) ? (WC_R - WP_CYC) : WPH_CYC;
  localparam int MAXC    = (WP_CYC > HI_CYC ? WP_CYC : HI_CYC) > (OEH_CYC > RD_CYC ? OEH_CYC : RD_CYC)
                         ? (WP_CYC > HI_CYC ? WP_CYC : HI_CYC) : (OEH_CYC > RD_CYC ? OEH_CYC : RD_CYC);
  localparam int CW      = $clog2(MAXC + 1);
  localparam int PW      = $clog2(POLL_LIMIT + 1);
  localparam logic [AW-1:0] UNLK_A = AW'(21'h05555);
  localparam logic [AW-1:0] UNLK_B = AW'(21'h02AAA);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_REC, S_RD} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [2:0]      step;
  logic [PW-1:0]   polls;
  logic [1:0]      op_q;
  logic [AW-1:0]   addr_q;
  logic [7:0]      data_q;
  logic [SEL_W-1:0] sel_q;
  logic            done_r, err_r;

  logic            is_prog, is_chip, exp7, last;
  logic [AW-1:0]   w_addr;
  logic [7:0]      w_data;

  assign is_prog = (op_q == 2'b00);
  assign is_chip = (op_q == 2'b10);
  assign exp7    = is_prog ? data_q[7] : 1'b1;
  assign last    = is_prog ? (step == 3'd3) : (step == 3'd5);

  always_comb begin
    case (step)
      3'd0:    begin w_addr = UNLK_A; w_data = 8'hAA; end
      3'd1:    begin w_addr = UNLK_B; w_data = 8'h55; end
      3'd2:    begin w_addr = UNLK_A; w_data = is_prog ? 8'hA0 : 8'h80; end
      3'd3:    begin w_addr = is_prog ? addr_q : UNLK_A; w_data = is_prog ? data_q : 8'hAA; end
      3'd4:    begin w_addr = UNLK_B; w_data = 8'h55; end
      default: begin w_addr = is_chip ? UNLK_A : addr_q; w_data = is_chip ? 8'h10 : 8'h30; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; polls <= '0;
      op_q <= '0; addr_q <= '0; data_q <= '0; sel_q <= '0;
      done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_op != 2'b11) begin
          op_q <= req_op; addr_q <= req_addr; data_q <= req_data; sel_q <= req_sel;
          step <= '0; polls <= '0; cnt <= CW'(WP_CYC - 1); st <= S_WLO;
        end
        S_WLO: if (cnt == '0) begin
          cnt <= CW'(HI_CYC - 1); st <= S_WHI;
        end else cnt <= cnt - 1'b1;
        S_WHI: if (cnt == '0) begin
          if (last) begin cnt <= CW'(OEH_CYC - 1); st <= S_REC; end
          else begin step <= step + 1'b1; cnt <= CW'(WP_CYC - 1); st <= S_WLO; end
        end else cnt <= cnt - 1'b1;
        S_REC: if (cnt == '0) begin
          cnt <= CW'(RD_CYC - 1); st <= S_RD;
        end else cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          if (fl_dq_in[7] == exp7) begin
            done_r <= 1'b1; st <= S_IDLE;
          end else if (polls == PW'(POLL_LIMIT - 1)) begin
            done_r <= 1'b1; err_r <= 1'b1; st <= S_IDLE;
          end else begin
            polls <= polls + 1'b1; cnt <= CW'(OEH_CYC - 1); st <= S_REC;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_r;
  assign err       = err_r;
  assign fl_we_n   = (st != S_WLO);
  assign fl_oe_n   = (st != S_RD);
  assign fl_dq_oe  = (st == S_WLO) || (st == S_WHI);
  assign fl_dq_out = fl_dq_oe ? w_data : 8'h00;
  assign fl_addr   = fl_dq_oe ? w_addr : (busy ? addr_q : '0);
  assign fl_cs_n   = busy ? ~(NCS'(1) << sel_q) : '1;
endmodule

module flash_seq_chk #(
  parameter int AW     = 21,
  parameter int NCS    = 4,
  parameter int WP_CYC = 1
)(
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           fl_we_n,
  input logic           fl_oe_n,
  input logic           fl_dq_oe,
  input logic [AW-1:0]  fl_addr,
  input logic [7:0]     fl_dq_out,
  input logic [NCS-1:0] fl_cs_n
);
  int lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= 0;
    else if (!fl_we_n) lo_run <= lo_run + 1;
    else lo_run <= 0;
  end

  // R8
  one_sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~fl_cs_n) == 1);
  // R8
  no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&fl_cs_n));
  // R5
  no_we_oe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R4
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> lo_run >= WP_CYC);
  // R4
  bus_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .NCS(NCS), .WP_CYC(WP_CYC)) u_flash_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_oe(fl_dq_oe),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_cs_n(fl_cs_n));

// File: tb/test_flash_seq.sv
module test_flash_seq;
  localparam int AW = 21, NCS = 4, SW = 2, PL = 16, CK = 10;
  localparam int E_WP  = (45 + CK - 1) / CK;
  localparam int E_WC  = (90 + CK - 1) / CK;
  localparam int E_WPH = (20 + CK - 1) / CK;
  localparam int E_HI  = (E_WC - E_WP > E_WPH) ? E_WC - E_WP : E_WPH;
  localparam int E_OEH = (10 + CK - 1) / CK;
  localparam int E_RD  = (90 + CK - 1) / CK;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic [SW-1:0] req_sel = 0;
  logic busy, done, err, fl_dq_oe, fl_we_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;
  logic [NCS-1:0] fl_cs_n;

  always #(CK/2) clk = ~clk;

  flash_seq #(.CLK_NS(CK), .AW(AW), .NCS(NCS), .SEL_W(SW), .POLL_LIMIT(PL)) i_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_sel(req_sel), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_cs_n(fl_cs_n));

  int errors = 0, checks = 0;
  int nw = 0, nreads = 0, busy_reads = 0;
  logic exp7 = 1'b1;
  logic [AW-1:0] wa [8];
  logic [7:0] wd [8];
  logic [NCS-1:0] wcs [8];
  int lo_run = 0, hi_run = 0, since = 0, min_lo = 999, min_hi = 999, min_rec = 999;
  int rd_run = 0, rd_len = -1;
  bit had = 0, prev_we = 1, prev_oe = 1;
  logic got_err;

  assign fl_dq_in = {(nreads < busy_reads) ? ~exp7 : exp7, 7'h2A};

  always @(posedge fl_we_n) if (rst_n === 1'b1 && nw < 8) begin
    wa[nw] = fl_addr; wd[nw] = fl_dq_out; wcs[nw] = fl_cs_n; nw++;
  end
  always @(posedge fl_oe_n) if (rst_n === 1'b1) nreads++;

  always @(negedge clk) if (rst_n) begin
    if (fl_we_n) begin
      if (!prev_we) begin
        if (lo_run < min_lo) min_lo = lo_run;
        lo_run = 0; hi_run = 1; since = 1; had = 1;
      end else begin hi_run++; since++; end
    end else begin
      if (prev_we && had && hi_run < min_hi) min_hi = hi_run;
      lo_run++;
    end
    if (!fl_oe_n) begin
      if (prev_oe && had && since < min_rec) min_rec = since;
      rd_run++;
    end else if (!prev_oe) begin
      rd_len = rd_run; rd_run = 0;
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [SW-1:0] s, input int nbusy, input logic e7);
    nw = 0; nreads = 0; busy_reads = nbusy; exp7 = e7;
    min_lo = 999; min_hi = 999; min_rec = 999; had = 0; rd_len = -1;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d; req_sel = s;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    got_err = err;
    chk(done === 1'b1 && busy === 1'b0, "R10 done seen with busy low", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
    chk(fl_cs_n === '1, "R8 selects released", fl_cs_n, 4'hF);
  endtask

  task automatic check_timing(input string tag);
    chk(min_lo >= E_WP, {tag, " R4 we low width"}, min_lo, E_WP);
    chk(min_hi >= E_HI, {tag, " R4 we high gap"}, min_hi, E_HI);
    chk(min_rec >= E_OEH, {tag, " R5 oe recovery"}, min_rec, E_OEH);
    chk(rd_len == E_RD, {tag, " R6 read length"}, rd_len, E_RD);
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0 && err === 0, "R1 status idle", {busy, done, err}, 0);
    chk(fl_we_n === 1 && fl_oe_n === 1 && fl_dq_oe === 0, "R1 strobes idle", {fl_we_n, fl_oe_n, fl_dq_oe}, 3'b110);
    chk(fl_cs_n === '1, "R1 selects idle", fl_cs_n, 4'hF);
  endtask

  task automatic t_program(input logic [7:0] d, input int nbusy, input logic [SW-1:0] s);
    logic [AW-1:0] a = 21'h1B3C4;
    logic [NCS-1:0] ecs = ~(NCS'(1) << s);
    run_op(2'b00, a, d, s, nbusy, d[7]);
    wait_done();
    chk(nw == 4, "R2 write count", nw, 4);
    chk(wa[0] == 21'h5555 && wd[0] == 8'hAA, "R2 first unlock", {wa[0], wd[0]}, {21'h5555, 8'hAA});
    chk(wa[1] == 21'h2AAA && wd[1] == 8'h55, "R2 second unlock", {wa[1], wd[1]}, {21'h2AAA, 8'h55});
    chk(wa[2] == 21'h5555 && wd[2] == 8'hA0, "R2 program command", {wa[2], wd[2]}, {21'h5555, 8'hA0});
    chk(wa[3] == a && wd[3] == d, "R2 data write", {wa[3], wd[3]}, {a, d});
    for (int i = 0; i < 4; i++) chk(wcs[i] == ecs, "R8 select index", wcs[i], ecs);
    chk(got_err == 0, "R6 no error", got_err, 0);
    chk(nreads == nbusy + 1, "R6 poll read count", nreads, nbusy + 1);
    check_timing("program");
  endtask

  task automatic t_erase(input bit chip);
    logic [AW-1:0] a = 21'h0A000;
    run_op(chip ? 2'b10 : 2'b01, a, 8'h00, 2'd1, 2, 1'b1);
    wait_done();
    chk(nw == 6, "R3 write count", nw, 6);
    chk(wd[2] == 8'h80 && wd[3] == 8'hAA && wa[4] == 21'h2AAA && wd[4] == 8'h55,
        "R3 erase prefix", {wd[2], wd[3], wd[4]}, {8'h80, 8'hAA, 8'h55});
    if (chip) chk(wa[5] == 21'h5555 && wd[5] == 8'h10, "R3 chip erase command", {wa[5], wd[5]}, {21'h5555, 8'h10});
    else      chk(wa[5] == a && wd[5] == 8'h30, "R3 sector erase command", {wa[5], wd[5]}, {a, 8'h30});
    chk(got_err == 0 && nreads == 3, "R6 erase completes on bit7=1", {got_err, 8'(nreads)}, 3);
    check_timing("erase");
  endtask

  task automatic t_timeout();
    run_op(2'b00, 21'h00010, 8'h7E, 2'd0, 1000, 1'b0);
    wait_done();
    chk(got_err == 1, "R7 error flagged", got_err, 1);
    chk(nreads == PL, "R7 read count at limit", nreads, PL);
  endtask

  task automatic t_ignore_busy();
    run_op(2'b00, 21'h00321, 8'h5A, 2'd3, 0, 1'b0);
    repeat (3) @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_addr = 21'h1FFFF; req_data = 8'hC3;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    chk(nw == 4 && wa[3] == 21'h00321 && wd[3] == 8'h5A, "R9 busy request ignored", {8'(nw), wd[3]}, {8'd4, 8'h5A});
  endtask

  task automatic t_bad_op();
    nw = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2'b11; req_addr = 21'h00040;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 0, "R9 reserved op not accepted", busy, 0);
    repeat (20) @(negedge clk);
    chk(nw == 0 && fl_cs_n === '1, "R9 reserved op no bus activity", nw, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_program(8'h85, 0, 2'd0);
    t_program(8'h05, 3, 2'd2);
    t_erase(1'b0);
    t_erase(1'b1);
    t_timeout();
    t_ignore_busy();
    t_bad_op();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule